// File: doc/BRIEF.md
# Controlled Clock Enable Generator

This block lives in one fast, free-running reference clock domain. From that reference it produces one-cycle-granular enable strobes for three controlled clocks. The first is a full-rate clock whose rising edge is the only edge that matters. The second is a full-rate clock whose falling edge is the only edge that matters. The third is a clock divided by an even ratio `DIV` with a 50% duty cycle, and both of its edges matter. Every edge that matters lines up with a reference rising edge. Downstream logic uses each enable as a qualifier on the reference clock. The block emits no enable for a don't-care edge, so such an edge cannot be controlled.

A group of active-high ready inputs, one bit per controlled clock, can halt controlled time. The stop is immediate. If any registered ready bit is low, the next edge that matters on every controlled clock is cancelled, including the implicit full-rate clock. A stall freezes the phase of the divided clock, so resuming never skips an edge. A wide counter reports how many controlled cycles have elapsed.

Top module: `ccg_clock_enables`

## Requirements
- R1: While `rst_i` is high at a rising edge, every enable output and `slow_lvl_o` read 0 after that edge, and `cnt_o` reads 0.
- R2: `rdy_i` is registered once. If any bit of `rdy_i` is low at rising edge t, then all four enables are 0 in the cycle that follows rising edge t+1.
- R3: In every cycle not stalled under R2, `en_fast_o` and `en_fastn_o` are both 1, so they stay high continuously.
- R4: Each ready bit on its own stalls every clock (bit 0 = rising-edge clock, bit 1 = falling-edge clock, bit 2 = divided clock). This includes the case where bit 0 stalls `en_fastn_o` and bit 1 stalls `en_fast_o`.
- R5: A phase counter runs 0..DIV-1 and advances only in non-stalled cycles. `en_slow_rise_o` is 1 exactly in non-stalled cycles at phase 0. `en_slow_fall_o` is 1 exactly in non-stalled cycles at phase DIV/2. Each pulse is one reference period wide.
- R6: The first cycle after reset is released, with all ready bits high, carries `en_slow_rise_o` = 1.
- R7: `slow_lvl_o` becomes 1 in the cycle after an `en_slow_rise_o` pulse and becomes 0 in the cycle after an `en_slow_fall_o` pulse. Otherwise it holds its value.
- R8: `cnt_o` increases by one in the cycle after each cycle in which `en_fast_o` is 1, and holds its value otherwise.
- R9: After a stall ends, the divided clock resumes at the phase where it was frozen. No edge that matters is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rdy_i | input | NRDY | Per-clock ready bits, active high |
| en_fast_o | output | 1 | Rising-edge enable for the full-rate clock |
| en_fastn_o | output | 1 | Falling-edge enable for the full-rate falling-edge clock |
| en_slow_rise_o | output | 1 | Rising-edge enable for the divided clock |
| en_slow_fall_o | output | 1 | Falling-edge enable for the divided clock |
| slow_lvl_o | output | 1 | Level of the divided clock |
| cnt_o | output | CW | Count of elapsed controlled cycles |

## Verification
The bench builds the block with DIV = 4 and NRDY = 3, so one period of the divided clock lasts only four reference cycles. A sweep therefore reaches every combination of ready bit, starting phase and stall length from one to three cycles. That covers stalls that begin exactly on a rise or fall pulse and stalls that span a whole half period. The bench also covers all bits low together and a reset applied in the middle of a run.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

    // Enables for the edges that matter, one field per controlled edge
    typedef struct packed {
        logic fast;   // rising edge of full-rate clock
        logic fastn;  // falling edge of full-rate falling-edge clock
        logic srise;  // rising edge of divided clock
        logic sfall;  // falling edge of divided clock
    } ccg_en_t;

endpackage

// File: rtl/ccg_ready_sync.sv
module ccg_ready_sync #(
    parameter int NRDY = 3
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NRDY-1:0] rdy_i,
    output logic            stall_o
);

    typedef struct packed {
        logic [NRDY-1:0] rdy;
    } rs_state_t;

    rs_state_t st_d, st_q;
    logic [NRDY-1:0] low_flag;

    always_comb begin
        st_d     = st_q;
        st_d.rdy = rdy_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.rdy <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // One low flag per ready bit; any one of them brakes every clock
    for (genvar g = 0; g < NRDY; g++) begin : g_low
        assign low_flag[g] = ~st_q.rdy[g];
    end

    assign stall_o = |low_flag;

endmodule

// File: rtl/ccg_phase_gen.sv
module ccg_phase_gen
    import ccg_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    stall_i,
    output ccg_en_t en_o,
    output logic    lvl_o
);

    localparam int            PW      = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] PH_HALF = PW'(DIV / 2);

    typedef struct packed {
        logic [PW-1:0] ph;
        ccg_en_t       en;
        logic          lvl;
    } pg_state_t;

    pg_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.en.fast  = ~stall_i;
        st_d.en.fastn = ~stall_i;
        st_d.en.srise = ~stall_i && (st_q.ph == '0);
        st_d.en.sfall = ~stall_i && (st_q.ph == PH_HALF);
        if (st_q.en.srise) begin
            st_d.lvl = 1'b1;
        end else if (st_q.en.sfall) begin
            st_d.lvl = 1'b0;
        end
        if (!stall_i) begin
            st_d.ph = (st_q.ph == PH_LAST) ? '0 : st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign lvl_o = st_q.lvl;

endmodule

// File: rtl/ccg_cycle_count.sv
module ccg_cycle_count #(
    parameter int CW = 64
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cc_state_t;

    cc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/ccg_clock_enables.sv
module ccg_clock_enables
    import ccg_pkg::*;
#(
    parameter int DIV  = 4,
    parameter int NRDY = 3,
    parameter int CW   = 64
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NRDY-1:0] rdy_i,
    output logic            en_fast_o,
    output logic            en_fastn_o,
    output logic            en_slow_rise_o,
    output logic            en_slow_fall_o,
    output logic            slow_lvl_o,
    output logic [CW-1:0]   cnt_o
);

    logic    stall;
    ccg_en_t en;

    ccg_ready_sync #(.NRDY(NRDY)) u_ready (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .rdy_i   (rdy_i),
        .stall_o (stall)
    );

    ccg_phase_gen #(.DIV(DIV)) u_phase (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .stall_i (stall),
        .en_o    (en),
        .lvl_o   (slow_lvl_o)
    );

    ccg_cycle_count #(.CW(CW)) u_count (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .inc_i (en.fast),
        .cnt_o (cnt_o)
    );

    assign en_fast_o      = en.fast;
    assign en_fastn_o     = en.fastn;
    assign en_slow_rise_o = en.srise;
    assign en_slow_fall_o = en.sfall;

endmodule

// File: rtl/ccg_clock_enables_chk.sv
module ccg_clock_enables_chk #(
    parameter int DIV  = 4,
    parameter int NRDY = 3,
    parameter int CW   = 64
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic [NRDY-1:0] rdy_i,
    input logic            en_fast_o,
    input logic            en_fastn_o,
    input logic            en_slow_rise_o,
    input logic            en_slow_fall_o,
    input logic            slow_lvl_o,
    input logic [CW-1:0]   cnt_o
);

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (!en_fast_o && !en_fastn_o && !en_slow_rise_o && !en_slow_fall_o
                   && !slow_lvl_o && cnt_o == '0)); // R1

    AST_BRAKE_ALL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(&rdy_i) |-> ##2 (!en_fast_o && !en_fastn_o && !en_slow_rise_o && !en_slow_fall_o)); // R4

    AST_FAST_PAIR: assert property (@(posedge clk_i) disable iff (rst_i)
        en_fast_o == en_fastn_o); // R3

    AST_SLOW_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(en_slow_rise_o && en_slow_fall_o)); // R5

    AST_RISE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        en_slow_rise_o |=> !en_slow_rise_o); // R5

    AST_LVL_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        en_slow_rise_o |=> slow_lvl_o); // R7

    AST_LVL_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        en_slow_fall_o |=> !slow_lvl_o); // R7

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        en_fast_o |=> (cnt_o == $past(cnt_o) + 1'b1)); // R8

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_fast_o |=> $stable(cnt_o)); // R8

endmodule

bind ccg_clock_enables ccg_clock_enables_chk #(
    .DIV  (DIV),
    .NRDY (NRDY),
    .CW   (CW)
) u_chk (.*);

// File: tb/ccg_clock_enables_tb.sv
module ccg_clock_enables_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int NRDY       = 3;
    localparam int CW         = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NRDY-1:0] rdy = '1;
    logic            en_fast, en_fastn, en_srise, en_sfall, lvl;
    logic [CW-1:0]   cnt;

    int nchk = 0;
    int nerr = 0;

    // Reference model state (values after the most recent rising edge)
    logic [NRDY-1:0] m_rdyq = '1;
    int              m_ph   = 0;
    logic            m_fast = 0, m_srise = 0, m_sfall = 0, m_lvl = 0;
    logic [CW-1:0]   m_cnt  = '0;
    logic            m_rst_prev = 1'b1;
    logic            m_first    = 0;
    logic            m_resume   = 0;
    logic            m_stalled  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccg_clock_enables #(.DIV(DIV), .NRDY(NRDY), .CW(CW)) u_dut (
        .clk_i          (clk),
        .rst_i          (rst),
        .rdy_i          (rdy),
        .en_fast_o      (en_fast),
        .en_fastn_o     (en_fastn),
        .en_slow_rise_o (en_srise),
        .en_slow_fall_o (en_sfall),
        .slow_lvl_o     (lvl),
        .cnt_o          (cnt)
    );

    task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update for one rising edge, from the requirements
    task automatic model_edge();
        logic stall;
        logic old_srise, old_sfall, old_fast;
        old_srise = m_srise;
        old_sfall = m_sfall;
        old_fast  = m_fast;
        if (rst) begin
            m_rdyq = '1; m_ph = 0; m_fast = 0; m_srise = 0; m_sfall = 0;
            m_lvl = 0; m_cnt = '0; m_first = 0; m_resume = 0; m_stalled = 0;
        end else begin
            stall    = (m_rdyq != '1);
            m_resume = m_stalled && !stall;
            m_first  = m_rst_prev;
            m_stalled = stall;
            m_fast   = !stall;
            m_srise  = !stall && (m_ph == 0);
            m_sfall  = !stall && (m_ph == DIV/2);
            if (old_srise) m_lvl = 1;
            else if (old_sfall) m_lvl = 0;
            if (old_fast) m_cnt = m_cnt + 1;
            if (!stall) m_ph = (m_ph + 1) % DIV;
            m_rdyq = rdy;
        end
        m_rst_prev = rst;
    endtask

    // One reference cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic r, input logic [NRDY-1:0] rd);
        rst = r;
        rdy = rd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst) begin
            chk("R1 en_fast", en_fast, 0);
            chk("R1 en_fastn", en_fastn, 0);
            chk("R1 srise", en_srise, 0);
            chk("R1 sfall", en_sfall, 0);
            chk("R1 lvl", lvl, 0);
            chk("R1 cnt", cnt, 0);
        end else begin
            chk(m_stalled ? "R2 en_fast stalled" : "R3 en_fast", en_fast, m_fast);
            chk(m_stalled ? "R4 en_fastn stalled" : "R3 en_fastn", en_fastn, m_fast);
            chk(m_first ? "R6 srise first" : (m_resume ? "R9 srise resume" : "R5 srise"),
                en_srise, m_srise);
            chk(m_resume ? "R9 sfall resume" : "R5 sfall", en_sfall, m_sfall);
            chk("R7 lvl", lvl, m_lvl);
            chk("R8 cnt", cnt, m_cnt);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nerr++;
        $display("FAIL watchdog (all requirements) act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset held over several edges, including with ready low
        cyc(1'b1, '1);
        cyc(1'b1, '0);
        cyc(1'b1, '1);
        // R6, R5, R7, R8: free run over several divided periods
        for (int i = 0; i < 12; i++) cyc(1'b0, '1);
        // R2, R4, R9: each ready bit, each starting phase, several stall lengths
        for (int b = 0; b < NRDY; b++) begin
            for (int o = 0; o < DIV; o++) begin
                for (int len = 1; len <= 3; len++) begin
                    for (int i = 0; i < o; i++) cyc(1'b0, '1);
                    for (int i = 0; i < len; i++) cyc(1'b0, ~(NRDY'(1) << b));
                    for (int i = 0; i < DIV + 2; i++) cyc(1'b0, '1);
                end
            end
        end
        // R2: all bits low together, and alternating stall/run
        for (int i = 0; i < 5; i++) cyc(1'b0, '0);
        for (int i = 0; i < 16; i++) cyc(1'b0, (i % 2 == 0) ? '1 : NRDY'(3'b101));
        for (int i = 0; i < 6; i++) cyc(1'b0, '1);
        // R1: reset in the middle of a run, then R6 restart
        cyc(1'b1, '1);
        cyc(1'b1, '1);
        for (int i = 0; i < 10; i++) cyc(1'b0, '1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule